// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This block sits beside a two-wire bus master and frees a bus left stuck by an interrupted transfer or a reset in the middle of a byte. A target that was cut off partway through sending data can still be holding the data line low. On a request, the sequencer pulls the clock line low and releases it again, one period at a time, and never touches the data line while it does so. At the end of each clock-high phase it looks at the data line. When the line has gone high, it drives a start condition (data pulled low while clock stays released), holds it, then pulls the clock low and finishes with a success status.

If the data line is still low after nine clock periods, it gives up. It releases both lines and finishes with a failure status. Both lines are open-drain: the outputs are pull-low enables that the master ORs with its own. A parameter sets the number of system clocks in each half period so that the minimum low and high widths are met. A second parameter sets the start hold time.

Top module: `twowire_unjam`

## Requirements
- R1: After a request, the sequencer issues between one and MAX_PULSES (default 9) clock-low phases, each followed by a clock-high phase. It stops after the first high phase in which the data line reads high at its last system clock.
- R2: While it is clocking, `sda_lo_o` stays 0. The data line is first pulled low only after a clock-high phase, with the clock released.
- R3: On success, the start condition pulls the data line low while the clock is released and holds it for HOLD_CYC system clocks. Then the clock is pulled low with the data line still held low, for HALF_CYC system clocks.
- R4: Every clock-low phase and every clock-high phase lasts exactly HALF_CYC system clocks.
- R5: If the data line is still low at the end of the MAX_PULSES-th high phase, no start is generated, `ok_o` is 0 with `done_o`, and both pull-low outputs are 0 from then on.
- R6: `done_o` is a single-cycle pulse in the first cycle after the sequence ends. `ok_o` (1 = freed and started, 0 = failed) is valid with it and holds until the next request.
- R7: A request that arrives while `busy_o` is 1 is ignored. The running sequence keeps its length: `busy_o` is high for 2·HALF_CYC·P + HOLD_CYC + HALF_CYC cycles on success, and 2·HALF_CYC·MAX_PULSES cycles on failure, with P the number of clock periods.
- R8: During and after reset, the block is idle with both lines released, `busy_o` = 0 and `done_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a recovery sequence (taken only when idle) |
| sda_i | input | 1 | Synchronised level of the data line |
| scl_lo_o | output | 1 | 1 = pull the clock line low |
| sda_lo_o | output | 1 | 1 = pull the data line low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ok_o | output | 1 | Result status: 1 bus freed and start sent, 0 failed |

## Verification
The bench builds the sequencer with HALF_CYC = 3, HOLD_CYC = 2 and MAX_PULSES = 9, so each full recovery takes only a few dozen cycles. This makes it cheap to sweep a modelled stuck target that releases the data line after every count of clock rises from 0 to 11. The sweep covers an already-free line, release on the very last allowed period, and both outcomes past the limit. Short phases also let every low, high, hold and final clamp phase be measured against its exact length. A request injected partway through a run checks that the total busy length is unchanged.

// File: rtl/twowire_unjam.sv
module twowire_unjam #(
  parameter int HALF_CYC   = 170,
  parameter int HOLD_CYC   = 80,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic sda_i,
  output logic scl_lo_o,
  output logic sda_lo_o,
  output logic busy_o,
  output logic done_o,
  output logic ok_o
);
  localparam int LONGEST = (HALF_CYC > HOLD_CYC) ? HALF_CYC : HOLD_CYC;
  localparam int CW = $clog2(LONGEST + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_LOW   = 3'd1;
  localparam logic [2:0] S_HIGH  = 3'd2;
  localparam logic [2:0] S_HOLD  = 3'd3;
  localparam logic [2:0] S_CLAMP = 3'd4;

  logic [2:0]    st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pulses;
  logic          tick;

  assign tick     = (cnt == '0);
  assign scl_lo_o = (st == S_LOW) || (st == S_CLAMP);
  assign sda_lo_o = (st == S_HOLD) || (st == S_CLAMP);
  assign busy_o   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      pulses <= '0;
      done_o <= 1'b0;
      ok_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_i) begin
            st     <= S_LOW;
            cnt    <= CW'(HALF_CYC - 1);
            pulses <= '0;
            ok_o   <= 1'b0;
          end
        end
        S_LOW: begin
          if (tick) begin
            st  <= S_HIGH;
            cnt <= CW'(HALF_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HIGH: begin
          if (!tick) begin
            cnt <= cnt - 1'b1;
          end else if (sda_i) begin
            st  <= S_HOLD;
            cnt <= CW'(HOLD_CYC - 1);
          end else if (pulses == PW'(MAX_PULSES - 1)) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
            ok_o   <= 1'b0;
          end else begin
            st     <= S_LOW;
            cnt    <= CW'(HALF_CYC - 1);
            pulses <= pulses + 1'b1;
          end
        end
        S_HOLD: begin
          if (tick) begin
            st  <= S_CLAMP;
            cnt <= CW'(HALF_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CLAMP: begin
          if (tick) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
            ok_o   <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twowire_unjam_chk.sv
module twowire_unjam_chk #(
  parameter int MAX_PULSES = 9,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic          scl_lo_o,
  input logic          sda_lo_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          ok_o,
  input logic [2:0]    st,
  input logic [PW-1:0] pulses
);
  a_r1_pulse_limit: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (pulses < PW'(MAX_PULSES)));

  a_r2_sda_free_clocking: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 || st == 3'd2) |-> !sda_lo_o);

  a_r3_start_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_lo_o) |-> (!scl_lo_o && !$past(scl_lo_o)));

  a_r5_fail_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ok_o) |-> (!scl_lo_o && !sda_lo_o));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (pulses >= $past(pulses)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> (!scl_lo_o && !sda_lo_o && !done_o));
endmodule

bind twowire_unjam twowire_unjam_chk #(.MAX_PULSES(MAX_PULSES), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .scl_lo_o(scl_lo_o),
  .sda_lo_o(sda_lo_o), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
  .st(st), .pulses(pulses)
);

// File: tb/twowire_unjam_tb_top.sv
module twowire_unjam_tb_top;
  localparam int HALF = 3;
  localparam int HOLD = 2;
  localparam int MAXP = 9;

  logic clk = 0;
  logic rst_n = 0;
  logic req = 0;
  logic sda;
  logic scl_lo, sda_lo, busy, done, ok;

  always #4 clk = ~clk;

  twowire_unjam #(.HALF_CYC(HALF), .HOLD_CYC(HOLD), .MAX_PULSES(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .sda_i(sda), .scl_lo_o(scl_lo),
    .sda_lo_o(sda_lo), .busy_o(busy), .done_o(done), .ok_o(ok)
  );

  int checks = 0;
  int errors = 0;
  int release_after = 100;
  int rises = 0;
  bit scl_prev = 1;
  bit target_hold;

  assign target_hold = (rises < release_after);
  assign sda = !sda_lo && !target_hold;

  int cur_kind = 0, prev_kind = 0, runlen = 0;
  int lows, highs, starts, bad_w, bad_hold, bad_order, busy_cnt, done_cnt, rel_bad;
  bit ok_seen;

  always @(negedge clk) begin
    int kind;
    bit scl_now;
    scl_now = !scl_lo;
    if (scl_now && !scl_prev) rises++;
    scl_prev = scl_now;
    if (!busy) kind = 0;
    else if (scl_lo && !sda_lo) kind = 1;
    else if (!scl_lo && !sda_lo) kind = 2;
    else if (!scl_lo && sda_lo) kind = 3;
    else kind = 4;
    if (kind == cur_kind) runlen++;
    else begin
      case (cur_kind)
        1: begin lows++; if (runlen != HALF) bad_w++; end
        2: begin highs++; if (runlen != HALF) bad_w++; end
        3: begin starts++; if (runlen != HOLD) bad_hold++; if (prev_kind != 2) bad_order++; end
        4: begin if (runlen != HALF) bad_w++; if (prev_kind != 3) bad_order++; end
        default: ;
      endcase
      prev_kind = cur_kind;
      cur_kind = kind;
      runlen = 1;
    end
    if (busy) busy_cnt++;
    if (done) begin
      done_cnt++;
      ok_seen = ok;
    end
    if (done_cnt > 0 && !busy && (scl_lo || sda_lo)) rel_bad++;
  end

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int k, input bit poke);
    int p, exp_busy, guard;
    bit succ;
    @(negedge clk);
    lows = 0; highs = 0; starts = 0; bad_w = 0; bad_hold = 0; bad_order = 0;
    busy_cnt = 0; done_cnt = 0; rel_bad = 0; ok_seen = 0;
    rises = 0;
    release_after = k;
    req = 1;
    @(negedge clk);
    req = 0;
    if (poke) begin
      repeat (7) @(negedge clk);
      req = 1;
      @(negedge clk);
      req = 0;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    p = (k < 1) ? 1 : ((k > MAXP) ? MAXP : k);
    succ = (k <= MAXP);
    exp_busy = succ ? (2 * HALF * p + HOLD + HALF) : (2 * HALF * MAXP);
    chk(guard < 1000, "R6 done seen (watchdog)", guard, 0);
    chk(lows == p, "R1 low phase count", lows, p);
    chk(highs == p, "R1 high phase count", highs, p);
    chk(bad_w == 0, "R4 phase widths", bad_w, 0);
    chk(bad_order == 0, "R2 sda released while clocking", bad_order, 0);
    chk(starts == (succ ? 1 : 0), succ ? "R3 start issued" : "R5 no start on fail", starts, succ ? 1 : 0);
    chk(bad_hold == 0, "R3 start hold width", bad_hold, 0);
    chk(busy_cnt == exp_busy, poke ? "R7 busy length with ignored request" : "R7 busy length", busy_cnt, exp_busy);
    chk(done_cnt == 1, "R6 done single pulse", done_cnt, 1);
    chk(ok_seen == succ, succ ? "R6 ok status" : "R5 fail status", ok_seen, succ);
    chk(ok == succ, "R6 status held", ok, succ);
    chk(rel_bad == 0, "R5 lines released after end", rel_bad, 0);
    chk(!busy && !scl_lo && !sda_lo, "R8 idle after run", {busy, scl_lo, sda_lo}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = 1;
    @(negedge clk);
    chk(!scl_lo && !sda_lo && !busy && !done, "R8 reset state", {scl_lo, sda_lo, busy, done}, 0);
    req = 0;
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R8 idle out of reset", {busy, done}, 0);
    for (int k = 0; k <= 11; k++) run(k, 1'b0);
    run(4, 1'b1);
    run(MAXP + 1, 1'b1);
    run(MAXP, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule